// File: doc/BRIEF.md
# Multi-domain reset and halt controller

This block turns four asynchronous, active-low control inputs into clean resets for two clock domains and a fetch-enable for the core. The four inputs are a system (power-on) reset, a core reset, a debug reset and a halt request. Any input may switch at any moment, and the driver does no synchronizing of its own. Each reset output asserts as soon as its source goes low and is released in step with its own clock: the core clock for the core reset, the debug clock for the debug reset.

The system reset acts as a cold reset, so both domains go down with it. The core reset alone is a warm reset: the core domain restarts and the debug domain keeps its state. The debug reset touches only the debug domain. Once the core domain leaves reset, a low halt request holds instruction fetch off. This holds only until fetch has started once. After that, the halt request is ignored until the next core or system reset.

A 3-bit mode code reports the decoded state in the core domain. A monitor flags warm reset pulses that are too short. All pins are plain level signals, because the block carries no data stream and so has no valid/ready handshake.

Top module: `rstctl_top`

## Requirements
- R1: `core_rst_n_o` goes low at once (without a clock edge) whenever `core_rst_n_i` or `sys_rst_n_i` is low. After both are high, it stays low through the first rising `clk_core` edge and goes high after the second.
- R2: `dbg_rst_n_o` goes low at once whenever `dbg_rst_n_i` or `sys_rst_n_i` is low. It goes high on the second rising `clk_dbg` edge after both are high. A core reset with the system reset high never pulls it low.
- R3: `mode_o` encodes the state as 0 = cold (core reset active and system reset active), 1 = warm (core reset active, system reset inactive), 2 = run, 3 = halted and 4 = debug reset only. An active core-domain reset outranks a debug reset, and a debug reset outranks halted and run.
- R4: With the core domain out of reset and `halt_n_i` high, `fetch_en_o` is 1 and `mode_o` is 2 within four core cycles.
- R5: If `halt_n_i` is low when the core domain leaves reset, and fetch has not started since that reset, `fetch_en_o` stays 0 and `mode_o` is 3.
- R6: Once `fetch_en_o` has been 1, a later low on `halt_n_i` has no effect. `fetch_en_o` stays 1 and `mode_o` stays 2 until the next core or system reset.
- R7: A core or system reset re-arms the halt request, so a low `halt_n_i` at the following release holds fetch again.
- R8: When the core reset rises after being seen low in fewer than 4 core cycles (`MIN_RST_CYCLES`), `short_rst_o` becomes 1 within three core cycles. A pulse of 4 or more cycles leaves it 0. The flag clears when the next core reset pulse begins, and while the system reset is low.
- R9: A debug-only reset leaves `core_rst_n_o` and `fetch_en_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core-domain clock |
| clk_dbg | input | 1 | Debug-domain clock, unrelated to clk_core |
| sys_rst_n_i | input | 1 | System / power-on reset, active low, asynchronous |
| core_rst_n_i | input | 1 | Core reset, active low, asynchronous |
| dbg_rst_n_i | input | 1 | Debug reset, active low, asynchronous |
| halt_n_i | input | 1 | Halt-after-reset request, active low, asynchronous |
| core_rst_n_o | output | 1 | Core-domain reset, active low, released on clk_core |
| dbg_rst_n_o | output | 1 | Debug-domain reset, active low, released on clk_dbg |
| fetch_en_o | output | 1 | Instruction fetch enable |
| mode_o | output | 3 | Decoded reset/run mode code |
| short_rst_o | output | 1 | Last warm core reset pulse was too short |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, the bench drops the debug reset and the core reset together. It then checks that the mode code shows the warm-reset code rather than the debug code, that both reset outputs are low, and that both are released correctly. In the second pair, a too-short warm reset pulse ends while the halt request is low. The short-pulse flag must then rise in the same release window in which the halt logic holds fetch off, and neither result may mask the other.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  typedef enum logic [2:0] {
    MODE_COLD = 3'd0,
    MODE_WARM = 3'd1,
    MODE_RUN  = 3'd2,
    MODE_HALT = 3'd3,
    MODE_DBG  = 3'd4
  } rst_mode_e;

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int STAGES = 2,
  parameter bit RVAL   = 1'b0
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) stg_q <= RVAL;
        else           stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) stg_q <= {STAGES{RVAL}};
        else           stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rstctl_pulse_mon.sv
module rstctl_pulse_mon #(
  parameter int STAGES  = 2,
  parameter int MIN_CYC = 4
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic lvl_n_i,
  output logic short_o
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);

  logic          mon;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          flag_q;

  rstctl_sync #(.STAGES(STAGES), .RVAL(1'b1)) u_lvl_sync (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .d_i      (lvl_n_i),
    .q_o      (mon)
  );

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= mon;
      if (prev_q && !mon) begin
        cnt_q  <= CW'(1);
        flag_q <= 1'b0;
      end else if (!mon && cnt_q != CMAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (!prev_q && mon) flag_q <= (cnt_q < CMAX);
    end
  end

  assign short_o = flag_q;

  AST_FLAG_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(short_o) |-> mon) else $error("flag rose while reset still seen"); // R8

  AST_FLAG_CLEARS_ON_FALL: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    ($past(prev_q) && !$past(mon)) |-> !short_o) else $error("flag not cleared at pulse start"); // R8

endmodule

// File: rtl/rstctl_mode.sv
module rstctl_mode
  import rstctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       core_rst_n_i,
  input  logic       sys_ok_i,
  input  logic       dbg_ok_i,
  input  logic       halt_n_i,
  output logic       fetch_en_o,
  output logic [2:0] mode_o
);

  logic      run_q;
  logic      fetch;
  rst_mode_e mode;

  assign fetch = core_rst_n_i & (halt_n_i | run_q);

  always_ff @(posedge clk_i or negedge core_rst_n_i) begin
    if (!core_rst_n_i) run_q <= 1'b0;
    else if (fetch)    run_q <= 1'b1;
  end

  always_comb begin
    if (!core_rst_n_i)  mode = sys_ok_i ? MODE_WARM : MODE_COLD;
    else if (!dbg_ok_i) mode = MODE_DBG;
    else if (!fetch)    mode = MODE_HALT;
    else                mode = MODE_RUN;
  end

  assign fetch_en_o = fetch;
  assign mode_o     = mode;

  AST_FETCH_STICKY: assert property (@(posedge clk_i) disable iff (!core_rst_n_i)
    fetch_en_o |=> fetch_en_o) else $error("fetch dropped without reset"); // R6

  AST_FETCH_START_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!core_rst_n_i)
    $rose(fetch_en_o) |-> halt_n_i) else $error("fetch started while halted"); // R5

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!core_rst_n_i)
    mode_o <= 3'd4) else $error("illegal mode code"); // R3

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top #(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_RST_CYCLES = 4
) (
  input  logic       clk_core,
  input  logic       clk_dbg,
  input  logic       sys_rst_n_i,
  input  logic       core_rst_n_i,
  input  logic       dbg_rst_n_i,
  input  logic       halt_n_i,
  output logic       core_rst_n_o,
  output logic       dbg_rst_n_o,
  output logic       fetch_en_o,
  output logic [2:0] mode_o,
  output logic       short_rst_o
);

  logic core_src_n;
  logic dbg_src_n;
  logic sys_ok;
  logic dbg_ok_core;
  logic halt_n_s;

  assign core_src_n = core_rst_n_i & sys_rst_n_i;
  assign dbg_src_n  = dbg_rst_n_i & sys_rst_n_i;

  rstctl_sync #(.STAGES(SYNC_STAGES), .RVAL(1'b0)) u_core_rst (
    .clk_i (clk_core), .arst_n_i (core_src_n), .d_i (1'b1), .q_o (core_rst_n_o)
  );

  rstctl_sync #(.STAGES(SYNC_STAGES), .RVAL(1'b0)) u_dbg_rst (
    .clk_i (clk_dbg), .arst_n_i (dbg_src_n), .d_i (1'b1), .q_o (dbg_rst_n_o)
  );

  rstctl_sync #(.STAGES(SYNC_STAGES), .RVAL(1'b0)) u_sys_seen (
    .clk_i (clk_core), .arst_n_i (sys_rst_n_i), .d_i (1'b1), .q_o (sys_ok)
  );

  rstctl_sync #(.STAGES(SYNC_STAGES), .RVAL(1'b0)) u_dbg_seen (
    .clk_i (clk_core), .arst_n_i (dbg_src_n), .d_i (1'b1), .q_o (dbg_ok_core)
  );

  rstctl_sync #(.STAGES(SYNC_STAGES), .RVAL(1'b0)) u_halt_sync (
    .clk_i (clk_core), .arst_n_i (core_src_n), .d_i (halt_n_i), .q_o (halt_n_s)
  );

  rstctl_mode u_mode (
    .clk_i        (clk_core),
    .core_rst_n_i (core_rst_n_o),
    .sys_ok_i     (sys_ok),
    .dbg_ok_i     (dbg_ok_core),
    .halt_n_i     (halt_n_s),
    .fetch_en_o   (fetch_en_o),
    .mode_o       (mode_o)
  );

  rstctl_pulse_mon #(.STAGES(SYNC_STAGES), .MIN_CYC(MIN_RST_CYCLES)) u_pulse_mon (
    .clk_i    (clk_core),
    .arst_n_i (sys_rst_n_i),
    .lvl_n_i  (core_rst_n_i),
    .short_o  (short_rst_o)
  );

  AST_CORE_RST_HOLDS: assert property (@(posedge clk_core) disable iff (!core_src_n)
    core_rst_n_o |=> core_rst_n_o) else $error("core reset fell without source"); // R1

  AST_CORE_RELEASE_SYNC: assert property (@(posedge clk_core) disable iff (!core_src_n)
    $rose(core_rst_n_o) |-> $past(core_src_n)) else $error("core reset released early"); // R1

  AST_DBG_UNTOUCHED: assert property (@(posedge clk_dbg) disable iff (!dbg_src_n)
    !$fell(dbg_rst_n_o)) else $error("debug reset fell without its source"); // R2

endmodule

// File: tb/rstctl_top_test.sv
module rstctl_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DBG_PERIOD = 14;

  logic clk_core = 1'b0;
  logic clk_dbg  = 1'b0;
  logic sys_n    = 1'b0;
  logic core_n   = 1'b0;
  logic dbg_n    = 1'b1;
  logic halt_n   = 1'b0;
  logic       core_rst_n_o, dbg_rst_n_o, fetch_en_o, short_rst_o;
  logic [2:0] mode_o;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_core = ~clk_core;
  always #(DBG_PERIOD/2) clk_dbg  = ~clk_dbg;

  rstctl_top uut (
    .clk_core     (clk_core),
    .clk_dbg      (clk_dbg),
    .sys_rst_n_i  (sys_n),
    .core_rst_n_i (core_n),
    .dbg_rst_n_i  (dbg_n),
    .halt_n_i     (halt_n),
    .core_rst_n_o (core_rst_n_o),
    .dbg_rst_n_o  (dbg_rst_n_o),
    .fetch_en_o   (fetch_en_o),
    .mode_o       (mode_o),
    .short_rst_o  (short_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_core(input int n);
    repeat (n) @(negedge clk_core);
  endtask

  task automatic t_reset_state;
    #1;
    chk("R1 core reset low at start", core_rst_n_o, 0);
    chk("R2 debug reset low under system reset", dbg_rst_n_o, 0);
    chk("R3 cold mode code", mode_o, 0);
    chk("R8 flag clear under system reset", short_rst_o, 0);
    chk("R4 no fetch in reset", fetch_en_o, 0);
  endtask

  task automatic t_cold_release_halted;
    wait_core(3);
    sys_n = 1'b1; core_n = 1'b1;
    @(negedge clk_core);
    chk("R1 still low after one edge", core_rst_n_o, 0);
    @(negedge clk_core);
    chk("R1 released after two edges", core_rst_n_o, 1);
    wait_core(4);
    chk("R5 halted mode", mode_o, 3);
    chk("R5 fetch held", fetch_en_o, 0);
    chk("R2 debug reset released", dbg_rst_n_o, 1);
    chk("R8 no flag after cold release", short_rst_o, 0);
  endtask

  task automatic t_sticky_run;
    halt_n = 1'b1;
    wait_core(4);
    chk("R4 fetch on in run", fetch_en_o, 1);
    chk("R4 run mode", mode_o, 2);
    halt_n = 1'b0;
    wait_core(5);
    chk("R6 late halt ignored fetch", fetch_en_o, 1);
    chk("R6 late halt ignored mode", mode_o, 2);
  endtask

  task automatic t_warm_rearm;
    core_n = 1'b0;
    #1;
    chk("R1 async assert on warm reset", core_rst_n_o, 0);
    wait_core(6);
    chk("R3 warm mode code", mode_o, 1);
    chk("R2 debug untouched by warm reset", dbg_rst_n_o, 1);
    core_n = 1'b1;
    wait_core(6);
    chk("R7 halt re-armed mode", mode_o, 3);
    chk("R7 halt re-armed fetch", fetch_en_o, 0);
    chk("R8 long pulse no flag", short_rst_o, 0);
    halt_n = 1'b1;
    wait_core(4);
  endtask

  task automatic t_short_pulse_with_halt;
    halt_n = 1'b0;
    core_n = 1'b0;
    wait_core(3);
    core_n = 1'b1;
    wait_core(6);
    chk("R8 three-cycle pulse flagged", short_rst_o, 1);
    chk("R5 halt still honoured with flag", mode_o, 3);
    halt_n = 1'b1;
    core_n = 1'b0;
    wait_core(3);
    chk("R8 flag cleared at pulse start", short_rst_o, 0);
    wait_core(1);
    core_n = 1'b1;
    wait_core(6);
    chk("R8 four-cycle pulse not flagged", short_rst_o, 0);
    chk("R4 run after warm reset", fetch_en_o, 1);
  endtask

  task automatic t_debug_only;
    @(negedge clk_dbg);
    dbg_n = 1'b0;
    #1;
    chk("R2 async debug reset", dbg_rst_n_o, 0);
    wait_core(5);
    chk("R3 debug-only mode code", mode_o, 4);
    chk("R9 fetch kept in debug reset", fetch_en_o, 1);
    chk("R9 core reset kept high", core_rst_n_o, 1);
    @(negedge clk_dbg);
    dbg_n = 1'b1;
    @(negedge clk_dbg);
    chk("R2 debug still low after one edge", dbg_rst_n_o, 0);
    @(negedge clk_dbg);
    chk("R2 debug released after two edges", dbg_rst_n_o, 1);
    wait_core(4);
    chk("R3 back to run mode", mode_o, 2);
  endtask

  task automatic t_core_and_debug;
    @(negedge clk_core);
    dbg_n = 1'b0; core_n = 1'b0;
    wait_core(5);
    chk("R3 core reset outranks debug", mode_o, 1);
    chk("R1 core reset low", core_rst_n_o, 0);
    chk("R2 debug reset low", dbg_rst_n_o, 0);
    dbg_n = 1'b1; core_n = 1'b1;
    wait_core(6);
    chk("R4 run after joint release", mode_o, 2);
    chk("R2 debug released after joint", dbg_rst_n_o, 1);
  endtask

  task automatic t_cold_again;
    sys_n = 1'b0; core_n = 1'b0;
    #1;
    chk("R2 system reset pulls debug", dbg_rst_n_o, 0);
    wait_core(4);
    chk("R3 cold code again", mode_o, 0);
    sys_n = 1'b1; core_n = 1'b1;
    wait_core(6);
    chk("R4 run after cold", mode_o, 2);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_cold_release_halted();
    t_sticky_run();
    t_warm_rearm();
    t_short_pulse_with_halt();
    t_debug_only();
    t_core_and_debug();
    t_cold_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule